// File: doc/BRIEF.md
# Sticky Alert Status Controller

This block gathers out-of-limit indications from a monitoring chip's channels and drives one active-low alert line towards a host. Temperature and supply-rail events land in a first status register. Diode-fault, fan and over-temperature events land in a second one. Every status bit is sticky: it records an event until software reads it and the condition has gone away. Events arrive as per-channel level inputs from the limit comparators, which sit outside this block.

Two mask registers decide which recorded events may pull the alert line low. A mask bit gates only the alert and never the recording of an event. Bit 7 of the first status register is a live summary of the whole second register, and the matching mask bit decides whether the second register as a whole may raise the alert. The alert stays off until software sets an enable bit in a configuration register.

Software reaches all registers through a small synchronous port. The port has an address, a write strobe, a read strobe and combinational read data.

Top module: `alert_status_ctrl`

## Requirements
- R1: A status bit sets on any clock edge where its event input is high, and it stays set after the event drops for as long as it is not read. Status 1 records events on bits 6, 5, 4, 2 and 1. Status 2 records events on bits 7 down to 1. Event inputs at other positions are ignored.
- R2: A read strobe on a status register clears only the bits whose event input is low in that cycle. A bit whose event is high in the strobe cycle stays set.
- R3: The read data shows the status value from before the read. The clear takes effect on the clock edge that ends the strobe cycle.
- R4: Status 1 bit 7 reads as the OR of all status 2 bits and follows them without storage.
- R5: A set mask bit keeps its source from pulling the alert low. The source's status bit still sets normally.
- R6: Mask 1 bit 7 masks the status 1 summary bit. With it clear, any set status 2 bit asserts the alert even when every mask 2 bit is 1. With it set, only status 2 bits that are unmasked in mask 2 assert the alert.
- R7: The alert is off after reset. It can assert only while configuration bit 0 is 1.
- R8: alert_n is registered and active low. It goes low on the clock edge after an enabled, unmasked status bit is set, and it returns high on the edge after the last such bit clears.
- R9: The register map is: address 0 for status 1, 1 for status 2, 2 for mask 1, 3 for mask 2 and 4 for configuration. Only mask 1 bits 7..4 and 2..1, mask 2 bits 7..1 and configuration bit 0 are storable, and the other bits read 0. Writes to the status addresses are ignored. Addresses 5 to 7 read 0.
- R10: After reset, every register reads 0 and alert_n is 1.
- R11: Once a source's status bit has cleared, clearing its mask bit re-arms the alert: nothing fires until the next event of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_grp1 | input | 8 | Level event inputs for status 1 (bits 6,5,4,2,1) |
| ev_grp2 | input | 8 | Level event inputs for status 2 (bits 7..1) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clear-on-read for status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench builds the block with its default 8-bit registers and 3-bit address. At that size the bench can walk all twelve event sources one by one. For each source it covers the unmasked path, the masked path with its re-arm, and clears attempted both while the event is present and after it has gone. It also sweeps every address with all-ones writes to confirm the storable-bit masks. The summary-bit rule is covered in each of its three mask settings, and the enable bit is toggled with an event pending.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd4;

  // Sticky update: an event sets, a read clears only bits whose event is gone.
  function automatic logic sticky_next(input logic q, input logic ev, input logic clr);
    return ev | (q & ~clr);
  endfunction

  // Any recorded, unmasked, implemented bit pending.
  function automatic logic any_pending(input logic [REG_W-1:0] st,
                                       input logic [REG_W-1:0] msk,
                                       input logic [REG_W-1:0] impl);
    return |(st & ~msk & impl);
  endfunction
endpackage

// File: rtl/ast_sticky_bank.sv
module ast_sticky_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr,
  output logic [W-1:0] q
);
  import alert_pkg::*;

  logic [W-1:0] ev_v;
  assign ev_v = ev & VALID;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= sticky_next(bit_q, ev_v[i], clr);
      end
      assign q[i] = bit_q;
    end else begin : g_none
      assign q[i] = ev_v[i];
    end
  end
endmodule

// File: rtl/ast_regfile.sv
module ast_regfile #(
  parameter int W = 8,
  parameter int AW = 3,
  parameter logic [W-1:0] M1_IMPL  = 8'hF6,
  parameter logic [W-1:0] M2_IMPL  = 8'hFE,
  parameter logic [W-1:0] CFG_IMPL = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  st1_view,
  input  logic [W-1:0]  st2_view,
  output logic [W-1:0]  mask1,
  output logic [W-1:0]  mask2,
  output logic [W-1:0]  cfg,
  output logic [W-1:0]  rdata,
  output logic          clr1,
  output logic          clr2
);
  import alert_pkg::*;

  logic wr_m1, wr_m2, wr_cfg;
  assign wr_m1  = wr && (addr == A_MASK1);
  assign wr_m2  = wr && (addr == A_MASK2);
  assign wr_cfg = wr && (addr == A_CFG);
  assign clr1   = rd && (addr == A_STAT1);
  assign clr2   = rd && (addr == A_STAT2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1 <= '0;
      mask2 <= '0;
      cfg   <= '0;
    end else begin
      if (wr_m1)  mask1 <= wdata & M1_IMPL;
      if (wr_m2)  mask2 <= wdata & M2_IMPL;
      if (wr_cfg) cfg   <= wdata & CFG_IMPL;
    end
  end

  always_comb begin
    case (addr)
      A_STAT1: rdata = st1_view;
      A_STAT2: rdata = st2_view;
      A_MASK1: rdata = mask1;
      A_MASK2: rdata = mask2;
      A_CFG:   rdata = cfg;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ast_alert_merge.sv
module ast_alert_merge #(
  parameter int W = 8,
  parameter logic [W-1:0] S1_IMPL = 8'hF6,
  parameter logic [W-1:0] S2_IMPL = 8'hFE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] st1_view,
  input  logic [W-1:0] st2_view,
  input  logic [W-1:0] mask1,
  input  logic [W-1:0] mask2,
  input  logic         en,
  output logic         pend1,
  output logic         pend2,
  output logic         alert_n
);
  import alert_pkg::*;

  assign pend1 = any_pending(st1_view, mask1, S1_IMPL);
  assign pend2 = any_pending(st2_view, mask2, S2_IMPL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= ~(en & (pend1 | pend2));
  end
endmodule

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl #(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 3,
  parameter int SUM_BIT = 7,
  parameter logic [REG_W-1:0] EV1_IMPL = 8'h76,
  parameter logic [REG_W-1:0] EV2_IMPL = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ev_grp1,
  input  logic [REG_W-1:0]  ev_grp2,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              alert_n
);
  localparam logic [REG_W-1:0] SUM_MSK = REG_W'(1) << SUM_BIT;
  localparam logic [REG_W-1:0] S1_IMPL = EV1_IMPL | SUM_MSK;

  logic [REG_W-1:0] st1_q, st2_q, st1_view;
  logic [REG_W-1:0] mask1, mask2, cfg;
  logic             clr1, clr2, cfg_en, pend1, pend2, sum_any;

  ast_sticky_bank #(.W(REG_W), .VALID(EV1_IMPL)) u_st1 (
    .clk(clk), .rst_n(rst_n), .ev(ev_grp1), .clr(clr1), .q(st1_q));
  ast_sticky_bank #(.W(REG_W), .VALID(EV2_IMPL)) u_st2 (
    .clk(clk), .rst_n(rst_n), .ev(ev_grp2), .clr(clr2), .q(st2_q));

  assign sum_any  = |st2_q;
  assign st1_view = (st1_q & ~SUM_MSK) | (sum_any ? SUM_MSK : '0);

  ast_regfile #(.W(REG_W), .AW(ADDR_W), .M1_IMPL(S1_IMPL), .M2_IMPL(EV2_IMPL)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .st1_view(st1_view), .st2_view(st2_q),
    .mask1(mask1), .mask2(mask2), .cfg(cfg), .rdata(reg_rdata),
    .clr1(clr1), .clr2(clr2));

  assign cfg_en = cfg[0];

  ast_alert_merge #(.W(REG_W), .S1_IMPL(S1_IMPL), .S2_IMPL(EV2_IMPL)) u_merge (
    .clk(clk), .rst_n(rst_n), .st1_view(st1_view), .st2_view(st2_q),
    .mask1(mask1), .mask2(mask2), .en(cfg_en),
    .pend1(pend1), .pend2(pend2), .alert_n(alert_n));
endmodule

// File: rtl/ast_checker.sv
module ast_checker #(
  parameter int W = 8,
  parameter int AW = 3,
  parameter logic [W-1:0] V2 = 8'hFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  ev_grp2,
  input logic [W-1:0]  st2_q,
  input logic          clr2,
  input logic          cfg_en,
  input logic          alert_n,
  input logic [AW-1:0] reg_addr,
  input logic [W-1:0]  reg_rdata
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr2 |=> ((st2_q & $past(st2_q)) == $past(st2_q)));

  p_ev_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_grp2 & V2)) |=> ((st2_q & $past(ev_grp2 & V2)) == $past(ev_grp2 & V2)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st2_q & ~$past(st2_q) & ~$past(ev_grp2)) == '0));

  p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[W-1] == (|st2_q)));

  p_off_when_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> alert_n);

  p_low_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> $past(cfg_en));
endmodule

bind alert_status_ctrl ast_checker #(.W(REG_W), .AW(ADDR_W), .V2(EV2_IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_grp2(ev_grp2), .st2_q(st2_q), .clr2(clr2),
  .cfg_en(cfg_en), .alert_n(alert_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata));

// File: tb/alert_status_ctrl_test.sv
module alert_status_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ev_grp1 = '0, ev_grp2 = '0, reg_wdata = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       alert_n;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alert_status_ctrl uut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int src_bit(input int s);
    case (s)
      0: return 6; 1: return 5; 2: return 4; 3: return 2; 4: return 1;
      default: return 12 - s;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R10 reset state
    check(alert_n === 1'b1, "R10 alert_n", alert_n, 1);
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), d);
      check(d === 8'h00, "R10 reg reset", d, 0);
    end

    // R9 map: storable bits, ignored status writes
    for (int a = 0; a < 8; a++) begin
      logic [7:0] e;
      wr(3'(a), 8'hFF);
      peek(3'(a), d);
      e = (a == 2) ? 8'hF6 : (a == 3) ? 8'hFE : (a == 4) ? 8'h01 : 8'h00;
      check(d === e, "R9 map", d, e);
      wr(3'(a), 8'h00);
    end

    // R1 ignored event inputs
    ev_grp1 = 8'h89; ev_grp2 = 8'h01;
    step(); ev_grp1 = 0; ev_grp2 = 0;
    peek(0, d); check(d === 8'h00, "R1 unused ev1", d, 0);
    peek(1, d); check(d === 8'h00, "R1 unused ev2", d, 0);

    wr(4, 8'h01);
    for (int s = 0; s < 12; s++) begin
      bit g2 = (s >= 5);
      int b = src_bit(s);
      logic [2:0] sa = g2 ? 3'd1 : 3'd0;
      logic [7:0] bm = 8'(1 << b);
      // unmasked path
      if (g2) ev_grp2 = bm; else ev_grp1 = bm;
      step(); step();
      check(alert_n === 1'b0, "R8 alert low", alert_n, 0);
      peek(sa, d); check(d[b] === 1'b1, "R1 set", d, bm);
      if (g2) begin
        peek(0, d); check(d[7] === 1'b1, "R4 summary set", d[7], 1);
      end
      rd(sa, d);
      peek(sa, d); check(d[b] === 1'b1, "R2 read while present", d, bm);
      ev_grp1 = 0; ev_grp2 = 0;
      step();
      peek(sa, d); check(d[b] === 1'b1, "R1 sticky", d, bm);
      rd(sa, d); check(d[b] === 1'b1, "R3 pre-clear data", d, bm);
      peek(sa, d); check(d === 8'h00, "R3 cleared", d, 0);
      if (g2) begin
        peek(0, d); check(d[7] === 1'b0, "R4 summary clear", d[7], 0);
      end
      step();
      check(alert_n === 1'b1, "R8 alert released", alert_n, 1);
      // masked path
      if (g2) begin wr(2, 8'h80); wr(3, bm); end else wr(2, bm);
      if (g2) ev_grp2 = bm; else ev_grp1 = bm;
      step(); step();
      check(alert_n === 1'b1, "R5 masked alert", alert_n, 1);
      peek(sa, d); check(d[b] === 1'b1, "R5 status still set", d, bm);
      ev_grp1 = 0; ev_grp2 = 0;
      step();
      rd(sa, d);
      // R11 re-arm
      wr(2, 8'h00); wr(3, 8'h00);
      step();
      check(alert_n === 1'b1, "R11 re-armed quiet", alert_n, 1);
      if (g2) ev_grp2 = bm; else ev_grp1 = bm;
      step(); ev_grp1 = 0; ev_grp2 = 0;
      step();
      check(alert_n === 1'b0, "R11 fires after re-arm", alert_n, 0);
      rd(sa, d); step(); step();
    end

    // R6 summary mask rule
    ev_grp2 = 8'h08; step(); ev_grp2 = 0; step();
    wr(3, 8'hFE); wr(2, 8'h00); step();
    check(alert_n === 1'b0, "R6 summary unmasked", alert_n, 0);
    wr(2, 8'h80); step();
    check(alert_n === 1'b1, "R6 summary masked", alert_n, 1);
    wr(3, 8'h00); step();
    check(alert_n === 1'b0, "R6 mask2 open", alert_n, 0);
    rd(1, d); wr(2, 0); step(); step();

    // R7 enable
    wr(4, 8'h00);
    ev_grp1 = 8'h40; step(); ev_grp1 = 0; step(); step();
    check(alert_n === 1'b1, "R7 disabled", alert_n, 1);
    wr(4, 8'h01); step();
    check(alert_n === 1'b0, "R7 enabled", alert_n, 0);
    rd(0, d); step(); step();

    // R2 event coincident with read
    ev_grp1 = 8'h10; step(); ev_grp1 = 0; step();
    ev_grp1 = 8'h10; rd(0, d); ev_grp1 = 0;
    peek(0, d); check(d[4] === 1'b1, "R2 coincident event", d, 8'h10);
    rd(0, d); peek(0, d); check(d === 8'h00, "R2 later clear", d, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule